// File: doc/BRIEF.md
# Parallel Systematic BCH Encoder, 18 Bits per Cycle

This block produces systematic BCH codewords for a burst-tolerant link. Every cycle it can take one 18-bit data block. Each accepted block goes to the output register unchanged in the next cycle. In the same cycle, a 198-bit remainder register advances by eighteen division steps at once.

A codeword holds 1782 bits, of which 1584 are message bits. It is sent as 88 message blocks followed by 11 check blocks. The code works over GF(2^11) and corrects up to 18 bit errors per codeword.

After the 88th message block the encoder stops taking input. It then unloads the remainder as 11 flagged check blocks through a word selector. After that it clears the remainder and accepts the next codeword. Both ports use a valid/ready handshake, and a stall at the output propagates back to the input.

Top module: `bch_sys_encoder`

## Requirements
- R1: After a synchronous reset, `out_valid` and `out_is_par` are 0, `in_ready` is 1, and any partly accumulated remainder is discarded.
- R2: A block accepted on `in_data` (`in_valid` and `in_ready` both high at a clock edge) appears on `out_data` in the next cycle, unchanged, with `out_valid`=1 and `out_is_par`=0.
- R3: The output carries 88 blocks with `out_is_par`=0, then 11 blocks with `out_is_par`=1, and this 99-block framing repeats for every codeword.
- R4: While check blocks 0 to 9 of a codeword are being presented, `in_ready` is 0, so no message block is taken during parity unloading.
- R5: The 198 check bits equal the remainder of m(x)·x^198 divided by g(x). The message polynomial m(x) is read with bit 17 of the first block as the coefficient of x^1583, most significant bit first within each block. Check block 0 carries coefficients x^197 down to x^180, with x^197 in bit 17, and each following block carries the next 18 lower coefficients.
- R6: The remainder starts from zero for every codeword. An all-zero message therefore yields all-zero check blocks, whatever came before it.
- R7: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_is_par` hold their values and `in_ready` is 0.
- R8: Idle cycles on the input, with `in_valid` low, do not alter the check blocks. When nothing is pending, `out_valid` returns to 0.
- R9: Each complete 99-block output codeword, read as a polynomial of degree below 1782, is divisible by g(x). Here g(x) is the product of the minimal polynomials of alpha^1, alpha^3, ..., alpha^35, where alpha is a root of x^11+x^2+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Encoder takes a block this cycle |
| in_data | input | 18 | Message block |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Downstream takes the output block |
| out_data | output | 18 | Message or check block |
| out_is_par | output | 1 | 1 when `out_data` is a check block |

## Verification
The bench drives the following message patterns, each with a known consequence for the check blocks:
- An all-zero message must give zero parity, including right after a random codeword, which exposes a remainder that is not cleared.
- An all-ones message and alternating patterns load every feedback tap.
- A single one in the first bit, the x^1583 term, gives x^1781 mod g.
- A single one in the last message bit must return exactly the low coefficients of g, which exposes a wrong tap position or wrong bit order.

Two pseudo-random messages, run with input gaps and with output stalls, separate the parity arithmetic from the handshake timing. Every codeword is also divided by an independently built g(x), one bit at a time.

// File: rtl/bchenc_pkg.sv
package bchenc_pkg;

  localparam int GF_M   = 11;
  localparam int CORR_T = 18;
  localparam logic [GF_M-1:0] PRIM_LOW = GF_M'(5);  // x^11 + x^2 + 1
  localparam int GEN_DEG = GF_M * CORR_T;

  typedef enum logic {
    PH_DATA   = 1'b0,
    PH_PARITY = 1'b1
  } phase_e;

  // GF(2^m) multiply, shift-and-add with modular reduction
  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                             input logic [GF_M-1:0] b);
    logic [GF_M-1:0] p;
    p = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      p = {p[GF_M-2:0], 1'b0} ^ (p[GF_M-1] ? PRIM_LOW : '0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // Product of the minimal polynomials of alpha^1, alpha^3, ... alpha^(2T-1)
  function automatic logic [GEN_DEG:0] gen_poly();
    logic [GEN_DEG:0]          g;
    logic [GEN_DEG:0]          acc;
    logic [GF_M-1:0]           beta;
    logic [(GF_M+1)*GF_M-1:0]  m;
    logic [(GF_M+1)*GF_M-1:0]  mn;
    g = (GEN_DEG + 1)'(1);
    for (int r = 1; r < 2 * CORR_T; r += 2) begin
      beta = GF_M'(1);
      for (int e = 0; e < r; e++) beta = gf_mul(beta, GF_M'(2));
      m = '0;
      m[GF_M-1:0] = GF_M'(1);
      for (int k = 0; k < GF_M; k++) begin
        mn = '0;
        mn[GF_M-1:0] = gf_mul(beta, m[GF_M-1:0]);
        for (int j = 1; j <= GF_M; j++) begin
          mn[j*GF_M +: GF_M] = gf_mul(beta, m[j*GF_M +: GF_M]) ^ m[(j-1)*GF_M +: GF_M];
        end
        m    = mn;
        beta = gf_mul(beta, beta);
      end
      acc = '0;
      for (int j = 0; j <= GF_M; j++) begin
        if (m[j*GF_M]) acc = acc ^ (g << j);
      end
      g = acc;
    end
    return g;
  endfunction

  localparam logic [GEN_DEG:0]   GEN_FULL = gen_poly();
  localparam logic [GEN_DEG-1:0] GEN_LOW  = GEN_FULL[GEN_DEG-1:0];

endpackage

// File: rtl/bchenc_lfsr.sv
// W serial division steps collapsed into one combinational update.
module bchenc_lfsr #(
  parameter int W  = 18,
  parameter int PW = 198,
  parameter logic [PW-1:0] GPOLY = '0
) (
  input  logic [PW-1:0] rem_in,
  input  logic [W-1:0]  din,
  output logic [PW-1:0] rem_out
);

  logic [PW-1:0] stage [W+1];

  assign stage[0] = rem_in;

  for (genvar s = 0; s < W; s++) begin : g_step
    logic fb;
    assign fb           = din[W-1-s] ^ stage[s][PW-1];
    assign stage[s+1]   = {stage[s][PW-2:0], 1'b0} ^ (fb ? GPOLY : '0);
  end

  assign rem_out = stage[W];

endmodule

// File: rtl/bchenc_parsel.sv
// Picks one W-bit word of the remainder, highest-degree word at index 0.
module bchenc_parsel #(
  parameter int W  = 18,
  parameter int NW = 11,
  localparam int PW = W * NW,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [PW-1:0] rem,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  word
);

  logic [W-1:0] words [NW];

  for (genvar j = 0; j < NW; j++) begin : g_word
    assign words[j] = rem[PW-1-j*W -: W];
  end

  always_comb begin
    word = '0;
    for (int j = 0; j < NW; j++) begin
      if (idx == IW'(j)) word = words[j];
    end
  end

endmodule

// File: rtl/bchenc_seq.sv
// Codeword framing: counts message blocks, then check blocks.
module bchenc_seq
  import bchenc_pkg::*;
#(
  parameter int DATA_BLKS = 88,
  parameter int PAR_BLKS  = 11,
  localparam int DW = $clog2(DATA_BLKS),
  localparam int IW = (PAR_BLKS > 1) ? $clog2(PAR_BLKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_fire,
  input  logic          par_fire,
  output phase_e        phase,
  output logic [IW-1:0] par_idx,
  output logic          last_par
);

  localparam logic [DW-1:0] LAST_D = DW'(DATA_BLKS - 1);
  localparam logic [IW-1:0] LAST_P = IW'(PAR_BLKS - 1);

  logic [DW-1:0] dcnt;

  assign last_par = (par_idx == LAST_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_DATA;
      dcnt    <= '0;
      par_idx <= '0;
    end else begin
      if (in_fire) begin
        if (dcnt == LAST_D) begin
          dcnt  <= '0;
          phase <= PH_PARITY;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
      if (par_fire) begin
        if (last_par) begin
          par_idx <= '0;
          phase   <= PH_DATA;
        end else begin
          par_idx <= par_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bch_sys_encoder.sv
module bch_sys_encoder
  import bchenc_pkg::*;
#(
  parameter int BLK_W     = 18,
  parameter int DATA_BLKS = 88,
  parameter int PAR_BLKS  = 11,
  parameter logic [BLK_W*PAR_BLKS-1:0] GPOLY = GEN_LOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic             out_is_par
);

  localparam int PW = BLK_W * PAR_BLKS;
  localparam int IW = (PAR_BLKS > 1) ? $clog2(PAR_BLKS) : 1;

  phase_e          phase;
  logic [IW-1:0]   par_idx;
  logic            last_par;
  logic            adv;
  logic            in_fire;
  logic            par_fire;
  logic [PW-1:0]   rem_q;
  logic [PW-1:0]   rem_next;
  logic [BLK_W-1:0] par_word;

  // output register may load when empty or being drained this cycle
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv && (phase == PH_DATA);
  assign in_fire  = in_valid && in_ready;
  assign par_fire = adv && (phase == PH_PARITY);

  bchenc_seq #(
    .DATA_BLKS(DATA_BLKS),
    .PAR_BLKS (PAR_BLKS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .in_fire (in_fire),
    .par_fire(par_fire),
    .phase   (phase),
    .par_idx (par_idx),
    .last_par(last_par)
  );

  bchenc_lfsr #(
    .W    (BLK_W),
    .PW   (PW),
    .GPOLY(GPOLY)
  ) u_lfsr (
    .rem_in (rem_q),
    .din    (in_data),
    .rem_out(rem_next)
  );

  bchenc_parsel #(
    .W (BLK_W),
    .NW(PAR_BLKS)
  ) u_sel (
    .rem (rem_q),
    .idx (par_idx),
    .word(par_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (in_fire) begin
      rem_q <= rem_next;
    end else if (par_fire && last_par) begin
      rem_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_is_par <= 1'b0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_data   <= in_data;
      out_is_par <= 1'b0;
    end else if (par_fire) begin
      out_valid  <= 1'b1;
      out_data   <= par_word;
      out_is_par <= 1'b1;
    end else if (adv) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/bchenc_chk.sv
module bchenc_chk #(
  parameter int W         = 18,
  parameter int DATA_BLKS = 88,
  parameter int PAR_BLKS  = 11
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_is_par
);

  localparam int TOTAL = DATA_BLKS + PAR_BLKS;
  localparam int OW    = $clog2(TOTAL);

  logic [OW-1:0] oc;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc <= '0;
    end else if (out_valid && out_ready) begin
      oc <= (oc == OW'(TOTAL - 1)) ? '0 : oc + 1'b1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !out_is_par && out_data == $past(in_data)));

  a_r3_flag_order: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is_par == (int'(oc) >= DATA_BLKS)));

  a_r4_ready_low_parity: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_par && oc != OW'(TOTAL - 1)) |-> !in_ready);

  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_par)));

  a_r7_stall_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind bch_sys_encoder bchenc_chk #(
  .W        (BLK_W),
  .DATA_BLKS(DATA_BLKS),
  .PAR_BLKS (PAR_BLKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_is_par(out_is_par)
);

// File: tb/bch_sys_encoder_test.sv
module bch_sys_encoder_test;

  localparam int W  = 18;
  localparam int ND = 88;
  localparam int NP = 11;
  localparam int NT = ND + NP;
  localparam int PW = W * NP;

  // vector: [3:0] message pattern, [4] input gaps, [5] output stalls
  localparam logic [5:0] VEC [0:7] = '{6'h00, 6'h01, 6'h02, 6'h13,
                                       6'h24, 6'h05, 6'h36, 6'h07};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_is_par;

  int n_chk = 0;
  int n_bad = 0;
  logic [PW:0] gb;
  int ex [0:2046];
  int lg [0:2047];

  always #5 clk = ~clk;

  bch_sys_encoder uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_is_par(out_is_par)
  );

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return ex[(lg[a] + lg[b]) % 2047];
  endfunction

  // generator from log/antilog tables, built independently of the design
  task automatic build_gen();
    int cf [0:11];
    logic [PW:0] acc;
    ex[0] = 1;
    for (int n = 1; n < 2047; n++) begin
      ex[n] = ex[n-1] << 1;
      if (ex[n] >= 2048) ex[n] = ex[n] ^ 32'h805;
    end
    for (int n = 0; n < 2047; n++) lg[ex[n]] = n;
    gb = '0;
    gb[0] = 1'b1;
    for (int r = 1; r < 36; r += 2) begin
      for (int j = 0; j < 12; j++) cf[j] = (j == 0) ? 1 : 0;
      for (int k = 0; k < 11; k++) begin
        int beta;
        beta = ex[(r << k) % 2047];
        for (int j = 11; j >= 1; j--) cf[j] = cf[j-1] ^ gmul(cf[j], beta);
        cf[0] = gmul(cf[0], beta);
      end
      acc = '0;
      for (int j = 0; j < 12; j++) if (cf[j] == 1) acc = acc ^ (gb << j);
      gb = acc;
    end
  endtask

  function automatic logic [W-1:0] mix(input int i, input logic [31:0] s);
    logic [31:0] x;
    x = (i * 32'h9E3779B1) ^ s;
    x = x ^ (x >> 13);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 16);
    return x[W-1:0];
  endfunction

  function automatic logic [W-1:0] blkgen(input int pat, input int i);
    case (pat)
      0: return '0;
      1: return '1;
      2: return (i == 0) ? 18'h20000 : 18'h0;
      3: return (i == ND - 1) ? 18'h00001 : 18'h0;
      4: return mix(i, 32'h01234567);
      5: return (i % 2 == 1) ? 18'h15555 : 18'h2AAAA;
      6: return mix(i, 32'h0C0FFEE1);
      default: return '0;
    endcase
  endfunction

  task automatic run_cw(input int pat, input bit gaps, input bit bp, input string preq);
    logic [W-1:0]  sent [ND];
    logic [W-1:0]  got  [NT];
    bit            gp   [NT];
    bit            r4ok;
    bit            r7ok;
    bit            dok;
    bit            fok;
    logic [PW-1:0] rem;
    logic [PW-1:0] par;
    logic [PW-1:0] dr;
    r4ok = 1'b1;
    r7ok = 1'b1;
    for (int i = 0; i < ND; i++) sent[i] = blkgen(pat, i);
    fork
      begin
        for (int i = 0; i < ND; i++) begin
          if (gaps && (i % 4 == 2)) repeat (2) begin
            @(negedge clk);
            in_valid = 1'b0;
          end
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = sent[i];
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int cnt;
        int cyc;
        bit held;
        logic [W-1:0] hd;
        bit hp;
        cnt = 0;
        cyc = 0;
        held = 1'b0;
        hd = '0;
        hp = 1'b0;
        while (cnt < NT) begin
          @(negedge clk);
          out_ready = !(bp && (cyc % 3 == 1));
          cyc++;
          #1;
          if (held && (!out_valid || out_data != hd || out_is_par != hp)) r7ok = 1'b0;
          if (out_valid && out_is_par && cnt >= ND && cnt < NT - 1 && in_ready) r4ok = 1'b0;
          if (out_valid && !out_ready) begin
            held = 1'b1;
            hd   = out_data;
            hp   = out_is_par;
            if (in_ready) r7ok = 1'b0;
          end else begin
            held = 1'b0;
          end
          if (out_valid && out_ready) begin
            got[cnt] = out_data;
            gp[cnt]  = out_is_par;
            cnt++;
          end
        end
      end
    join

    rem = '0;
    for (int i = 0; i < ND; i++) begin
      for (int b = W - 1; b >= 0; b--) begin
        logic fb;
        fb  = sent[i][b] ^ rem[PW-1];
        rem = {rem[PW-2:0], 1'b0};
        if (fb) rem = rem ^ gb[PW-1:0];
      end
    end

    dok = 1'b1;
    for (int i = 0; i < ND; i++) if (got[i] != sent[i]) dok = 1'b0;
    check(dok, "R2 data blocks", PW'(got[0]), PW'(sent[0]));

    fok = 1'b1;
    for (int i = 0; i < NT; i++) if (gp[i] != (i >= ND)) fok = 1'b0;
    check(fok, "R3 flag framing", PW'(fok), PW'(1));

    for (int j = 0; j < NP; j++) par[PW-1-j*W -: W] = got[ND + j];
    check(par == rem, preq, par, rem);

    dr = '0;
    for (int i = 0; i < NT; i++) begin
      for (int b = W - 1; b >= 0; b--) begin
        logic fb;
        fb = dr[PW-1];
        dr = {dr[PW-2:0], got[i][b]};
        if (fb) dr = dr ^ gb[PW-1:0];
      end
    end
    check(dr == '0, "R9 divisible by g", dr, '0);

    check(r4ok, "R4 in_ready low in parity", PW'(r4ok), PW'(1));
    check(r7ok, "R7 hold under stall", PW'(r7ok), PW'(1));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    build_gen();
    check(gb[PW] == 1'b1, "R9 generator degree", PW'(gb[PW]), PW'(1));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1 out_valid after reset", PW'(out_valid), '0);
    check(!out_is_par, "R1 out_is_par after reset", PW'(out_is_par), '0);
    check(in_ready, "R1 in_ready after reset", PW'(in_ready), PW'(1));
    out_ready = 1'b1;

    for (int v = 0; v < 8; v++) begin
      string req;
      if (v == 7) req = "R6 zero parity after random";
      else if (VEC[v][4]) req = "R8 parity with input gaps";
      else req = "R5 parity value";
      run_cw(int'(VEC[v][3:0]), VEC[v][4], VEC[v][5], req);
    end

    @(negedge clk);
    #1;
    check(!out_valid, "R8 output idles", PW'(out_valid), '0);
    check(in_ready, "R8 ready when idle", PW'(in_ready), PW'(1));

    // stall with one block held, then reset mid-codeword
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 18'h15A5A;
    #1;
    check(in_ready, "R7 empty register accepts", PW'(in_ready), PW'(1));
    @(negedge clk);
    in_data = 18'h3FFFF;
    #1;
    check(out_valid && !out_is_par && out_data == 18'h15A5A, "R2 next-cycle passthrough",
          PW'(out_data), PW'(18'h15A5A));
    check(!in_ready, "R7 input blocked", PW'(in_ready), '0);
    repeat (2) begin
      @(negedge clk);
      #1;
      check(out_valid && out_data == 18'h15A5A, "R7 data stable", PW'(out_data), PW'(18'h15A5A));
    end
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst       = 1'b0;
    out_ready = 1'b1;
    #1;
    check(!out_valid, "R1 reset drops output", PW'(out_valid), '0);
    check(in_ready, "R1 reset restores ready", PW'(in_ready), PW'(1));
    run_cw(4, 1'b0, 1'b0, "R6 remainder cleared by reset");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule